// File: doc/BRIEF.md
# Cascaded Biquad Sequencer

This block filters a stream of signed Q1.15 samples through a chain of second-order IIR sections. Each section uses the Direct Form I structure. All sections share one 16x16 multiply-accumulate datapath, so each sample is worked through the sections one after another. The result of a section is the input of the next section. The output of the last section is the filter output. A host writes the five coefficients and the scale shift of every section into small register files before streaming starts. It then issues one clear, and after that it presents each sample with a start strobe.

The sample history lives in a shared store of 2*NSEC+2 words. Each signal in the chain has two words: the filter input, the output of every inner section, and the final output. The two history words of a section's output are the same words that the following section reads as its input history. When a sample ends, a phase bit flips. This turns the newest word of each pair into the older word, and no data is copied. After its five products are summed, each section rounds the sum and takes the high word. It then applies an arithmetic left shift by a power of two and saturates the result to the Q1.15 range. The scale shift is what lets the host use coefficients of magnitude above 1.0.

Top module: `biquad_seq`

## Requirements
- R1: While reset is asserted and after its release, busy and done are low and dout is zero. All coefficient, shift and history words reset to zero.
- R2: Each section computes y = sat(floor((b2*x(n-2) + b1*x(n-1) + b0*x(n) + a2*y(n-2) + a1*y(n-1) + 2^14) / 2^15) * 2^sh). The feedback products are added, not subtracted. All operands are signed Q1.15 and sat clamps to [-32768, 32767].
- R3: Coefficient word 5*s+j belongs to section s, with j = 0 for b2, 1 for b1, 2 for b0, 3 for a2 and 4 for a1. Shift entry s holds the left shift (0 to 15) of section s. Writes to addresses beyond the last word have no effect.
- R4: The first section takes the sample latched on the accepted start. Section s+1 takes the output of section s, and dout carries the output of the last section.
- R5: For every section, x(n-1) and x(n-2) are its two previous inputs and y(n-1) and y(n-2) are its two previous outputs. A section's output history is the same as the next section's input history.
- R6: A sum whose shifted high word is out of range gives 32767 when positive and -32768 when negative.
- R7: After the clock edge that accepts a start, busy is high for exactly 7*NSEC+6 cycles. done is a one-cycle pulse in the last of these cycles. dout is valid from that cycle on and holds until the next run's done.
- R8: A start that arrives while busy is ignored. It does not change the current run's result or length, and it does not begin another run.
- R9: clr zeroes the whole history store and the phase bit and ends any run. The same samples sent after two separate clears give the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of history and sequencer |
| start | input | 1 | Sample strobe, accepted only when idle |
| din | input | DW | Input sample, Q1.15 |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | CAW | Coefficient word address (5*section + tap) |
| coef_data | input | DW | Coefficient value, Q1.15 |
| shift_we | input | 1 | Scale shift write enable |
| shift_addr | input | SAW | Section index for the shift write |
| shift_data | input | SHW | Left shift amount |
| busy | output | 1 | High for the whole run |
| done | output | 1 | One-cycle pulse with the final output |
| dout | output | DW | Filter output, Q1.15 |

## Verification
The assertions assume that the host writes the coefficient and shift files only between runs. They also assume that a clear comes after reset and before the first sample, and that inputs change synchronously to the clock. The bench follows these rules: it loads every file while busy is low, it clears before each group of samples, and it raises start only once per run, except for one deliberate strobe placed mid-run to exercise the rule that a start during a run is ignored.

// File: rtl/biquad_seq_pkg.sv
package biquad_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_SEC  = 2'd2,
        ST_POST = 2'd3
    } seq_state_e;

    localparam int TAPS     = 5;
    localparam int SEC_CYC  = 7;
    localparam int PRE_CYC  = 2;
    localparam int POST_CYC = 4;
    localparam int STEPW    = 3;
endpackage

// File: rtl/biquad_regfile.sv
module biquad_regfile #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [N-1:0][W-1:0] mem_d, mem_q;

    for (genvar i = 0; i < N; i++) begin : g_word
        always_comb begin
            if (clr)
                mem_d[i] = '0;
            else if (we && (waddr == AW'(i)))
                mem_d[i] = wdata;
            else
                mem_d[i] = mem_q[i];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (raddr == AW'(i))
                rdata = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mem_q <= '0;
        else
            mem_q <= mem_d;
    end
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
    parameter int DW   = 16,
    parameter int ACCW = 36
) (
    input  logic signed [ACCW-1:0] acc_in,
    input  logic                   clear_acc,
    input  logic                   add_round,
    input  logic signed [DW-1:0]   opd,
    input  logic signed [DW-1:0]   coef,
    output logic signed [ACCW-1:0] acc_out
);
    localparam logic signed [ACCW-1:0] HALF =
        {{(ACCW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};

    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] prod_ext;
    logic signed [ACCW-1:0] base;

    always_comb begin
        prod     = opd * coef;
        prod_ext = $signed({{(ACCW-2*DW){prod[2*DW-1]}}, prod});
        base     = clear_acc ? '0 : acc_in;
        acc_out  = base + (add_round ? HALF : prod_ext);
    end
endmodule

// File: rtl/biquad_scale.sv
module biquad_scale #(
    parameter int DW   = 16,
    parameter int ACCW = 36,
    parameter int SHW  = 4
) (
    input  logic signed [ACCW-1:0] acc,
    input  logic [SHW-1:0]         sh,
    output logic signed [DW-1:0]   y
);
    localparam int WW = ACCW + (1 << SHW);
    localparam logic signed [WW-1:0] MAXV = $signed({{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [WW-1:0] MINV = $signed({{(WW-DW+1){1'b1}}, {(DW-1){1'b0}}});

    logic signed [WW-1:0] hi_ext;
    logic signed [WW-1:0] shifted;

    always_comb begin
        hi_ext  = $signed({{(1 << SHW){acc[ACCW-1]}}, acc}) >>> (DW-1);
        shifted = hi_ext <<< sh;
        if (shifted > MAXV)
            y = MAXV[DW-1:0];
        else if (shifted < MINV)
            y = MINV[DW-1:0];
        else
            y = shifted[DW-1:0];
    end
endmodule

// File: rtl/biquad_seq.sv
module biquad_seq
    import biquad_seq_pkg::*;
#(
    parameter int NSEC = 3,
    parameter int DW   = 16,
    parameter int SHW  = 4,
    localparam int NCOEF = TAPS * NSEC,
    localparam int CAW   = $clog2(NCOEF),
    localparam int SAW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 start,
    input  logic signed [DW-1:0] din,
    input  logic                 coef_we,
    input  logic [CAW-1:0]       coef_addr,
    input  logic [DW-1:0]        coef_data,
    input  logic                 shift_we,
    input  logic [SAW-1:0]       shift_addr,
    input  logic [SHW-1:0]       shift_data,
    output logic                 busy,
    output logic                 done,
    output logic signed [DW-1:0] dout
);
    localparam int DEPTH = 2 * NSEC + 2;
    localparam int DAW   = $clog2(DEPTH);
    localparam int ACCW  = 2 * DW + 4;

    typedef struct packed {
        seq_state_e             st;
        logic [STEPW-1:0]       step;
        logic [SAW-1:0]         sec;
        logic                   ph;
        logic signed [DW-1:0]   xcur;
        logic signed [ACCW-1:0] acc;
        logic signed [DW-1:0]   y;
    } core_t;

    core_t d, q;

    logic [CAW-1:0]         coef_raddr;
    logic [DW-1:0]          coef_rdata;
    logic [SHW-1:0]         shift_rdata;
    logic [DAW-1:0]         dly_raddr, dly_waddr;
    logic [DW-1:0]          dly_rdata, dly_wdata;
    logic                   dly_we;
    logic                   mac_clear, mac_round;
    logic signed [DW-1:0]   opd;
    logic signed [ACCW-1:0] mac_acc;
    logic signed [DW-1:0]   scaled;

    // word of signal p that holds the older (odd=0) or newer (odd=1) sample
    function automatic logic [DAW-1:0] slot(input int p, input logic ph, input logic newer);
        return DAW'(2 * p + ((ph ^ newer) ? 1 : 0));
    endfunction

    biquad_regfile #(.W(DW), .N(NCOEF), .AW(CAW)) u_coef (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
        .raddr(coef_raddr), .rdata(coef_rdata)
    );

    biquad_regfile #(.W(SHW), .N(NSEC), .AW(SAW)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .we(shift_we), .waddr(shift_addr), .wdata(shift_data),
        .raddr(q.sec), .rdata(shift_rdata)
    );

    biquad_regfile #(.W(DW), .N(DEPTH), .AW(DAW)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .we(dly_we), .waddr(dly_waddr), .wdata(dly_wdata),
        .raddr(dly_raddr), .rdata(dly_rdata)
    );

    biquad_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
        .acc_in(q.acc), .clear_acc(mac_clear), .add_round(mac_round),
        .opd(opd), .coef($signed(coef_rdata)), .acc_out(mac_acc)
    );

    biquad_scale #(.DW(DW), .ACCW(ACCW), .SHW(SHW)) u_scale (
        .acc(q.acc), .sh(shift_rdata), .y(scaled)
    );

    always_comb begin
        d = q;
        coef_raddr = CAW'(TAPS * int'(q.sec) + int'(q.step));
        case (q.step)
            3'd0:    dly_raddr = slot(int'(q.sec), q.ph, 1'b0);
            3'd1:    dly_raddr = slot(int'(q.sec), q.ph, 1'b1);
            3'd3:    dly_raddr = slot(int'(q.sec) + 1, q.ph, 1'b0);
            3'd4:    dly_raddr = slot(int'(q.sec) + 1, q.ph, 1'b1);
            default: dly_raddr = slot(int'(q.sec), q.ph, 1'b0);
        endcase
        opd       = (q.step == 3'd2) ? q.xcur : $signed(dly_rdata);
        mac_clear = (q.step == 3'd0);
        mac_round = (q.step == 3'd5);
        dly_we    = 1'b0;
        dly_waddr = slot(int'(q.sec), q.ph, 1'b0);
        dly_wdata = q.xcur;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.xcur = din;
                    d.st   = ST_PRE;
                    d.step = '0;
                end
            end
            ST_PRE: begin
                if (q.step == STEPW'(PRE_CYC - 1)) begin
                    d.st   = ST_SEC;
                    d.step = '0;
                    d.sec  = '0;
                end else begin
                    d.step = q.step + 1'b1;
                end
            end
            ST_SEC: begin
                if (q.step != STEPW'(SEC_CYC - 1)) begin
                    d.acc  = mac_acc;
                    d.step = q.step + 1'b1;
                end else begin
                    dly_we = 1'b1;
                    d.xcur = scaled;
                    d.step = '0;
                    if (q.sec == SAW'(NSEC - 1))
                        d.st = ST_POST;
                    else
                        d.sec = q.sec + 1'b1;
                end
            end
            ST_POST: begin
                if (q.step == 3'd0) begin
                    dly_we    = 1'b1;
                    dly_waddr = slot(NSEC, q.ph, 1'b0);
                    d.y       = q.xcur;
                end
                if (q.step == 3'd1)
                    d.ph = ~q.ph;
                if (q.step == STEPW'(POST_CYC - 1)) begin
                    d.st   = ST_IDLE;
                    d.step = '0;
                end else begin
                    d.step = q.step + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (clr) begin
            d.st   = ST_IDLE;
            d.step = '0;
            d.sec  = '0;
            d.ph   = 1'b0;
            dly_we = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign busy = (q.st != ST_IDLE);
    assign done = (q.st == ST_POST) && (q.step == STEPW'(POST_CYC - 1));
    assign dout = q.y;
endmodule

// File: rtl/biquad_seq_chk.sv
module biquad_seq_chk #(
    parameter int NSEC = 3,
    parameter int DW   = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] dout
);
    localparam int RUNLEN = 7 * NSEC + 6;

    logic [15:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (busy)
            run_cnt <= run_cnt + 16'd1;
        else
            run_cnt <= '0;
    end

    a_r7_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 16'(RUNLEN - 1)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr |=> !busy);

    a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(done) || $past(clr)));

    a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(dout));

    a_r8_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !clr) |=> busy);

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !clr) |=> busy);

    a_r9_clr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !busy);
endmodule

bind biquad_seq biquad_seq_chk #(.NSEC(NSEC), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
    .busy(busy), .done(done), .dout(dout)
);

// File: tb/biquad_seq_bench.sv
module biquad_seq_bench;
    localparam int NS     = 3;
    localparam int RUNLEN = 7 * NS + 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        start = 1'b0;
    logic signed [15:0] din = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        shift_we = 1'b0;
    logic [1:0]  shift_addr = '0;
    logic [3:0]  shift_data = '0;
    logic        busy, done;
    logic signed [15:0] dout;

    always #2 clk = ~clk;

    biquad_seq #(.NSEC(NS)) u_biquad_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .din(din),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .shift_we(shift_we), .shift_addr(shift_addr), .shift_data(shift_data),
        .busy(busy), .done(done), .dout(dout)
    );

    int    nchk = 0;
    int    nfail = 0;
    bit    finished = 0;
    string cur_req = "R4";
    int    cf [NS][5];
    int    shv [NS];
    int    hist [NS+1][2];
    int    exp_q [$];
    int    rec [6];

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sec_model(input int s, input int x, input int x1,
                                     input int x2, input int y1, input int y2);
        longint acc, hi, v;
        acc = longint'(cf[s][0]) * x2 + longint'(cf[s][1]) * x1 + longint'(cf[s][2]) * x
            + longint'(cf[s][3]) * y2 + longint'(cf[s][4]) * y1 + 64'sd16384;
        hi = acc >>> 15;
        v  = hi * (longint'(1) << shv[s]);
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    function automatic int model_step(input int x);
        int sig [NS+1];
        sig[0] = x;
        for (int s = 0; s < NS; s++)
            sig[s+1] = sec_model(s, sig[s], hist[s][0], hist[s][1], hist[s+1][0], hist[s+1][1]);
        for (int p = 0; p <= NS; p++) begin
            hist[p][1] = hist[p][0];
            hist[p][0] = sig[p];
        end
        return sig[NS];
    endfunction

    task automatic clear_hist();
        for (int p = 0; p <= NS; p++) begin
            hist[p][0] = 0;
            hist[p][1] = 0;
        end
    endtask

    task automatic set_coef(input int s, input int j, input int v);
        cf[s][j] = v;
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 4'(s * 5 + j); coef_data = 16'(v);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic set_shift(input int s, input int v);
        shv[s] = v;
        @(negedge clk);
        shift_we = 1'b1; shift_addr = 2'(s); shift_data = 4'(v);
        @(negedge clk);
        shift_we = 1'b0;
    endtask

    task automatic set_section(input int s, input int b2, input int b1, input int b0,
                               input int a2, input int a1, input int sh);
        set_coef(s, 0, b2); set_coef(s, 1, b1); set_coef(s, 2, b0);
        set_coef(s, 3, a2); set_coef(s, 4, a1); set_shift(s, sh);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        clear_hist();
        chk("R9", int'(busy), 0);
    endtask

    task automatic send(input int x, input bit poke);
        int cnt;
        exp_q.push_back(model_step(x));
        @(negedge clk);
        din = 16'(x); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        forever begin
            if (busy) cnt++;
            if (done || cnt > 1000) break;
            if (poke) begin
                start = (cnt == 10);
                din   = 16'sh5a5a;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R7", cnt, RUNLEN);
        @(negedge clk);
        chk("R7", int'(busy), 0);
        chk("R7", int'(done), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R8 actual=extra_done expected=no_done");
            end else begin
                chk(cur_req, int'(dout), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R7 actual=hung expected=run_complete");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < NS; s++) begin
            for (int j = 0; j < 5; j++) cf[s][j] = 0;
            shv[s] = 0;
        end
        clear_hist();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(busy), 0);
        chk("R1", int'(done), 0);
        chk("R1", int'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(busy), 0);
        do_clear();
        cur_req = "R1";
        send(12000, 1'b0);
        chk("R1", int'(dout), 0);

        // R3: distinct taps in section 0, unity-ish pass in 1 and 2
        set_section(0, 4096, 8192, 16384, -2048, 6144, 0);
        set_section(1, 0, 0, 16384, 0, 0, 1);
        set_section(2, 0, 0, 16384, 0, 0, 1);
        set_coef(0, 15, 777);   // beyond last word: must not land anywhere
        cf[0][15 % 5] = cf[0][15 % 5];
        do_clear();
        cur_req = "R3";
        send(16000, 1'b0);
        for (int i = 0; i < 5; i++) send(0, 1'b0);
        send(-9000, 1'b0);

        // R6: saturation both ways with shift 3
        set_section(0, 0, 0, 32767, 0, 0, 3);
        do_clear();
        cur_req = "R6";
        send(20000, 1'b0);
        chk("R6", int'(dout), 32767);
        send(-20000, 1'b0);
        chk("R6", int'(dout), -32768);
        send(100, 1'b0);

        // R2 / R5 / R4: feedback in every section
        set_section(0, 2048, 4096, 2048, -8192, 24576, 1);
        set_section(1, 3000, -6000, 3000, -4096, 16384, 0);
        set_section(2, 1024, 2048, 1024, -12000, 20000, 2);
        do_clear();
        cur_req = "R5";
        lf = 16'hace1;
        for (int i = 0; i < 30; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send(int'($signed(lf)) >>> 1, 1'b0);
        end
        cur_req = "R2";
        send(32767, 1'b0);
        send(-32768, 1'b0);

        // R8: a start during a run is ignored
        cur_req = "R8";
        send(5000, 1'b1);
        send(-7000, 1'b1);
        repeat (RUNLEN + 4) @(negedge clk);
        chk("R8", int'(busy), 0);

        // R9: two clears give identical responses
        do_clear();
        cur_req = "R9";
        for (int i = 0; i < 6; i++) begin
            send((i == 0) ? 20000 : -1000 * i, 1'b0);
            rec[i] = int'(dout);
        end
        do_clear();
        for (int i = 0; i < 6; i++) begin
            send((i == 0) ? 20000 : -1000 * i, 1'b0);
            chk("R9", int'(dout), rec[i]);
        end

        repeat (4) @(negedge clk);
        chk("R8", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule